// File: doc/BRIEF.md
# Dirty Block Range Tracker

This block watches a stream of memory write strobes, each tagged with a block address, and records the span of blocks that have been written since it was last cleared. It holds a low bound and a high bound of block addresses, plus a two-bit status. The status reports that nothing has been written, that exactly one block has been written, or that a span of blocks has been written.

The first write after a clear raises an interrupt request. That request stays high until software clears the tracker. Software clears it by issuing a processor configuration read to a fixed clearing address. Block size is a parameter: the write address is a byte address, and the block number is taken from its upper bits.

Top module: `dirty_range_tracker`

## Requirements
- R1: After reset the status is 2'b00 (clear), both bounds are zero and irq_o is low.
- R2: A write while clear loads the written block number into both bounds, sets the status to 2'b01 (single block) and raises irq_o on the next cycle.
- R3: While the status is single block or range, a write to a block number above the high bound updates only the high bound, and a write below the low bound updates only the low bound.
- R4: A write to a block number different from the bound while in single block moves the status to 2'b11 (range).
- R5: While in range, a write to a block number equal to either bound or lying between them leaves the status and both bounds unchanged.
- R6: A configuration read whose address equals the parameter CLR_ADDR (default 8'hEC) zeroes both bounds, sets the status to 2'b00 and drops irq_o on the next cycle. Reads at other addresses have no effect.
- R7: irq_o stays high from the first write after a clear until the clearing read, whatever writes follow.
- R8: When a write and a clearing read occur in the same cycle, the clear wins and the write has no effect.
- R9: The block number is the write byte address shifted right by log2(BLK_BYTES) bits (default BLK_BYTES=64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_vld_i | input | 1 | Memory write strobe |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| cfg_rd_i | input | 1 | Processor configuration read strobe |
| cfg_addr_i | input | CFG_W | Configuration register address |
| lo_blk_o | output | BLK_W | Low bound block number |
| hi_blk_o | output | BLK_W | High bound block number |
| status_o | output | 2 | 00 clear, 01 single block, 11 range |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are writes that land exactly on a bound, and a write that coincides with a clearing read. Both need earlier writes to put the tracker in a known state first.

The stimulus therefore runs directed sequences before any random traffic:
- Writes that open a range, then writes on each bound, inside the range, and just beyond each side.
- Writes in the same cycle as a clearing read.
- Reads at addresses next to the clearing address.

After that, a random phase draws block numbers from a narrow pool, so that equal and neighbouring blocks recur often. A behavioural model is compared against the outputs on every clock.

// File: rtl/dirty_range_pkg.sv
package dirty_range_pkg;
  typedef enum logic [1:0] {
    ST_CLEAR  = 2'b00,
    ST_SINGLE = 2'b01,
    ST_RANGE  = 2'b11
  } trk_state_e;
endpackage

// File: rtl/blk_addr_map.sv
module blk_addr_map #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  localparam int OFS_W    = $clog2(BLK_BYTES),
  localparam int BLK_W    = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BLK_W-1:0]  blk_o
);
  assign blk_o = addr_i[ADDR_W-1:OFS_W];
endmodule

// File: rtl/range_cmp.sv
module range_cmp #(
  parameter int BLK_W = 26
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0] lo_i,
  input  logic [BLK_W-1:0] hi_i,
  output logic             below_o,
  output logic             above_o
);
  assign below_o = blk_i < lo_i;
  assign above_o = blk_i > hi_i;
endmodule

// File: rtl/dirty_range_tracker.sv
module dirty_range_tracker
  import dirty_range_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          BLK_BYTES = 64,
  parameter int          CFG_W     = 8,
  parameter logic [7:0]  CLR_ADDR  = 8'hEC,
  localparam int         BLK_W     = ADDR_W - $clog2(BLK_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              cfg_rd_i,
  input  logic [CFG_W-1:0]  cfg_addr_i,
  output logic [BLK_W-1:0]  lo_blk_o,
  output logic [BLK_W-1:0]  hi_blk_o,
  output logic [1:0]        status_o,
  output logic              irq_o
);
  trk_state_e       state_q, state_d;
  logic [BLK_W-1:0] lo_q, lo_d, hi_q, hi_d, blk;
  logic             irq_q, irq_d, below, above, clr;

  // R9: block number from the upper address bits
  blk_addr_map #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_map (
    .addr_i(wr_addr_i), .blk_o(blk));

  range_cmp #(.BLK_W(BLK_W)) u_cmp (
    .blk_i(blk), .lo_i(lo_q), .hi_i(hi_q), .below_o(below), .above_o(above));

  assign clr = cfg_rd_i && (cfg_addr_i == CFG_W'(CLR_ADDR));

  always_comb begin
    state_d = state_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    irq_d   = irq_q;
    if (clr) begin // R8: clear outranks a write
      state_d = ST_CLEAR;
      lo_d    = '0;
      hi_d    = '0;
      irq_d   = 1'b0;
    end else if (wr_vld_i) begin
      if (state_q == ST_CLEAR) begin
        state_d = ST_SINGLE;
        lo_d    = blk;
        hi_d    = blk;
        irq_d   = 1'b1;
      end else if (below || above) begin
        state_d = ST_RANGE;
        if (below) lo_d = blk;
        if (above) hi_d = blk;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CLEAR;
      lo_q    <= '0;
      hi_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      irq_q   <= irq_d;
    end
  end

  assign lo_blk_o = lo_q;
  assign hi_blk_o = hi_q;
  assign status_o = state_q;
  assign irq_o    = irq_q;

  assert_bounds_ordered_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_q <= hi_q);

  assert_first_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b00 && wr_vld_i && !clr) |=> (status_o == 2'b01 && irq_o));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (status_o == 2'b00 && !irq_o && lo_blk_o == '0 && hi_blk_o == '0));

  assert_irq_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr) |=> irq_o);

  assert_range_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b11 && !clr) |=> status_o == 2'b11);

  assert_irq_matches_status_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (status_o != 2'b00));

  assert_range_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b11 && !clr && (!wr_vld_i || (!below && !above)))
      |=> ($stable(lo_blk_o) && $stable(hi_blk_o)));
endmodule

// File: tb/dirty_range_tracker_bench.sv
module dirty_range_tracker_bench;
  localparam int ADDR_W = 32, BLK_BYTES = 64, CFG_W = 8, SH = 6;
  localparam int BLK_W = ADDR_W - SH;

  logic clk = 0, rst_ni = 0;
  logic wr_vld = 0, cfg_rd = 0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CFG_W-1:0] cfg_addr = '0;
  logic [BLK_W-1:0] lo_o, hi_o;
  logic [1:0] st_o;
  logic irq_o;

  int n_cmp = 0, n_bad = 0;
  int m_lo = 0, m_hi = 0, m_st = 0;
  bit m_irq = 0;

  always #5 clk = ~clk;

  dirty_range_tracker u_dirty_range_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .wr_vld_i(wr_vld), .wr_addr_i(wr_addr),
    .cfg_rd_i(cfg_rd), .cfg_addr_i(cfg_addr), .lo_blk_o(lo_o), .hi_blk_o(hi_o),
    .status_o(st_o), .irq_o(irq_o));

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(string req);
    chk({req, " status"}, st_o, m_st);
    chk({req, " lo"}, lo_o, m_lo);
    chk({req, " hi"}, hi_o, m_hi);
    chk({req, " irq"}, irq_o, m_irq);
  endtask

  // behavioural reference, applied at each edge
  function automatic void model_step();
    int b;
    b = int'(wr_addr >> SH);
    if (cfg_rd && cfg_addr == 8'hEC) begin
      m_st = 0; m_lo = 0; m_hi = 0; m_irq = 0;                 // R6 R8
    end else if (wr_vld) begin
      if (m_st == 0) begin
        m_st = 1; m_lo = b; m_hi = b; m_irq = 1;               // R2
      end else if (b < m_lo || b > m_hi) begin
        if (b < m_lo) m_lo = b;                                // R3
        if (b > m_hi) m_hi = b;
        m_st = 3;                                              // R4
      end                                                      // R5
    end
  endfunction

  // drive one cycle, then compare after the edge
  task automatic cyc(bit w, int blk, int ofs, bit r, int ra, string req);
    wr_vld = w; wr_addr = ADDR_W'(blk * BLK_BYTES + ofs);
    cfg_rd = r; cfg_addr = CFG_W'(ra);
    @(posedge clk);
    model_step();
    #2;
    compare(req);
    wr_vld = 0; cfg_rd = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1;
    compare("R1");
    repeat (2) @(posedge clk);
    #2 rst_ni = 1;
    #1 compare("R1");
    cyc(0, 0, 0, 1, 8'hEB, "R6 other addr");
    cyc(1, 20, 63, 0, 0, "R2 R9 first write");
    cyc(1, 20, 5, 0, 0, "R4 same block stays single");
    cyc(1, 25, 0, 0, 0, "R4 R3 above");
    cyc(1, 10, 0, 0, 0, "R3 below");
    cyc(1, 10, 1, 0, 0, "R5 on lo");
    cyc(1, 25, 7, 0, 0, "R5 on hi");
    cyc(1, 17, 0, 0, 0, "R5 inside");
    cyc(1, 26, 0, 0, 0, "R3 just above");
    cyc(1, 9, 0, 0, 0, "R3 just below");
    cyc(0, 0, 0, 1, 8'hED, "R6 other addr");
    cyc(0, 0, 0, 1, 8'hEC, "R6 clear");
    cyc(1, 5, 0, 1, 8'hEC, "R8 write with clear");
    cyc(1, 7, 0, 0, 0, "R2 first after clear");
    cyc(1, 3, 0, 0, 0, "R4 below from single");
    cyc(1, 3, 0, 1, 8'hEC, "R8 clear wins");
    cyc(1, 0, 0, 0, 0, "R2 block zero");
    cyc(1, 0, 0, 0, 0, "R7 irq holds");
    for (int i = 0; i < 3000; i++) begin
      int b = $urandom_range(0, 12) + 100;
      bit r = ($urandom_range(0, 40) == 0);
      int ra = $urandom_range(0, 3) ? 8'hEC : 8'hEE;
      cyc($urandom_range(0, 2) != 0, b, $urandom_range(0, 63), r, ra, "R7 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule